// File: doc/BRIEF.md
# Compound Branch Condition Evaluator

This unit settles whether a conditional jump is taken and what the next program counter becomes. On each strobe it compares two register operands, picks one of four status flags, merges the two according to a two-bit combining mode, and then chooses the next PC. If the jump is taken, the next PC is either the immediate word that follows the instruction or that word plus the current PC. If the jump is not taken, the PC steps over the immediate word.

The result is registered. `valid_o` pulses one cycle after `valid_i`, and `taken_o` and `next_pc_o` keep their values until the next strobe. Fetching the immediate word and reading the register file are done outside this unit. The caller presents `pc_i` as the address of the immediate word.

Top module: `branch_eval`

## Requirements
- R1: `cond_i[1:0]` selects an unsigned comparison of operand A against operand B: 0 equal, 1 not equal, 2 A less than B, 3 A less than or equal to B.
- R2: With comparison 0, the comparison is true whenever `idx_a_i` equals `idx_b_i`, whatever the operand values.
- R3: `cond_i[3:2]` selects the flag from `flags_i`, whose bits are: bit 0 overflow, bit 1 zero, bit 2 sign, bit 3 parity.
- R4: `cond_i[5:4]` selects how comparison C and flag F combine: 0 gives C, 1 gives C or F, 2 gives C and not F, 3 gives C or not F.
- R5: When the jump is taken and `rel_i` is 0, `next_pc_o` equals `imm_i`.
- R6: When the jump is taken and `rel_i` is 1, `next_pc_o` equals `imm_i + pc_i` modulo 2^32.
- R7: When the jump is not taken, `next_pc_o` equals `pc_i + 1` modulo 2^32.
- R8: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high. `taken_o` and `next_pc_o` update only on a strobe and otherwise hold their values.
- R9: After reset, `valid_o`, `taken_o` and `next_pc_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Evaluate strobe |
| idx_a_i | input | 5 | Register index of operand A |
| idx_b_i | input | 5 | Register index of operand B |
| val_a_i | input | 32 | Operand A value |
| val_b_i | input | 32 | Operand B value |
| flags_i | input | 4 | Status flags {parity, sign, zero, overflow} |
| cond_i | input | 6 | Condition: combine mode, flag select, compare select |
| rel_i | input | 1 | 1 selects a PC-relative target |
| pc_i | input | 32 | Address of the immediate word |
| imm_i | input | 32 | Immediate target word |
| valid_o | output | 1 | Result valid pulse |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 32 | Next program counter |

## Verification
The assertions assume that every input is stable and known in any cycle where `valid_i` is high. They relate each registered output only to the inputs sampled at the previous edge, so they rely on the caller not expecting a result in the same cycle. The stimulus changes inputs only on the falling clock edge and raises `valid_i` for a single cycle at a time. Between strobes it changes the inputs while `valid_i` is low, which tests that the outputs hold.

// File: rtl/branch_pkg.sv
package branch_pkg;
  typedef enum logic [1:0] {CMP_EQ, CMP_NE, CMP_LT, CMP_LE} cmp_sel_e;
  typedef enum logic [1:0] {FLG_OVF, FLG_ZERO, FLG_SIGN, FLG_PAR} flag_sel_e;
  typedef enum logic [1:0] {MIX_CMP, MIX_OR, MIX_ANDN, MIX_ORN} mix_sel_e;
  typedef struct packed {
    mix_sel_e  mix;
    flag_sel_e flag;
    cmp_sel_e  cmp;
  } cond_t;
endpackage

// File: rtl/br_compare.sv
module br_compare
  import branch_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  cmp_sel_e          sel_i,
  input  logic [IDX_W-1:0]  idx_a_i,
  input  logic [IDX_W-1:0]  idx_b_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              hit_o
);
  always_comb begin
    unique case (sel_i)
      CMP_EQ:  hit_o = (idx_a_i == idx_b_i) || (a_i == b_i); // same index short-cut
      CMP_NE:  hit_o = (a_i != b_i);
      CMP_LT:  hit_o = (a_i < b_i);
      default: hit_o = (a_i <= b_i);
    endcase
  end
endmodule

// File: rtl/br_combine.sv
module br_combine
  import branch_pkg::*;
#(
  parameter int NFLAG = 4
) (
  input  logic [NFLAG-1:0] flags_i,
  input  flag_sel_e        flag_sel_i,
  input  mix_sel_e         mix_i,
  input  logic             cmp_i,
  output logic             take_o
);
  logic f;
  assign f = flags_i[flag_sel_i];

  always_comb begin
    unique case (mix_i)
      MIX_CMP:  take_o = cmp_i;
      MIX_OR:   take_o = cmp_i | f;
      MIX_ANDN: take_o = cmp_i & ~f;
      default:  take_o = cmp_i | ~f;
    endcase
  end
endmodule

// File: rtl/br_target.sv
module br_target #(
  parameter int PC_W = 32
) (
  input  logic            take_i,
  input  logic            rel_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] imm_i,
  output logic [PC_W-1:0] next_pc_o
);
  localparam logic [PC_W-1:0] Step = PC_W'(1);
  logic [PC_W-1:0] jump_pc;

  assign jump_pc   = rel_i ? imm_i + pc_i : imm_i;
  assign next_pc_o = take_i ? jump_pc : pc_i + Step;
endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import branch_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int PC_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [IDX_W-1:0]  idx_a_i,
  input  logic [IDX_W-1:0]  idx_b_i,
  input  logic [DATA_W-1:0] val_a_i,
  input  logic [DATA_W-1:0] val_b_i,
  input  logic [3:0]        flags_i,
  input  logic [5:0]        cond_i,
  input  logic              rel_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   imm_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [PC_W-1:0]   next_pc_o
);
  cond_t           cond;
  logic            cmp_hit, take;
  logic [PC_W-1:0] next_pc;

  assign cond = cond_t'(cond_i);

  br_compare #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cmp (
    .sel_i  (cond.cmp),
    .idx_a_i(idx_a_i),
    .idx_b_i(idx_b_i),
    .a_i    (val_a_i),
    .b_i    (val_b_i),
    .hit_o  (cmp_hit)
  );

  br_combine #(.NFLAG(4)) u_mix (
    .flags_i   (flags_i),
    .flag_sel_i(cond.flag),
    .mix_i     (cond.mix),
    .cmp_i     (cmp_hit),
    .take_o    (take)
  );

  br_target #(.PC_W(PC_W)) u_tgt (
    .take_i   (take),
    .rel_i    (rel_i),
    .pc_i     (pc_i),
    .imm_i    (imm_i),
    .next_pc_o(next_pc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      taken_o   <= 1'b0;
      next_pc_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        taken_o   <= take;
        next_pc_o <= next_pc;
      end
    end
  end
endmodule

// File: rtl/branch_eval_checker.sv
module branch_eval_checker #(
  parameter int IDX_W = 5,
  parameter int PC_W  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [IDX_W-1:0] idx_a_i,
  input logic [IDX_W-1:0] idx_b_i,
  input logic [5:0]       cond_i,
  input logic             rel_i,
  input logic [PC_W-1:0]  pc_i,
  input logic [PC_W-1:0]  imm_i,
  input logic             valid_o,
  input logic             taken_o,
  input logic [PC_W-1:0]  next_pc_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;

  p_reset_r9: assert property (@(posedge clk_i)
    !rst_ni |=> (!valid_o && !taken_o && next_pc_o == '0));

  p_valid_delay_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (valid_o == $past(valid_i)));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(valid_i)) |-> ($stable(taken_o) && $stable(next_pc_o)));

  p_same_idx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o && $past(cond_i) == 6'd0 && $past(idx_a_i) == $past(idx_b_i))
      |-> taken_o);

  p_abs_target_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o && taken_o && !$past(rel_i)) |-> next_pc_o == $past(imm_i));

  p_rel_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o && taken_o && $past(rel_i))
      |-> next_pc_o == $past(imm_i) + $past(pc_i));

  p_skip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o && !taken_o) |-> next_pc_o == $past(pc_i) + PC_W'(1));
endmodule

bind branch_eval branch_eval_checker #(.IDX_W(IDX_W), .PC_W(PC_W)) i_branch_eval_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .idx_a_i  (idx_a_i),
  .idx_b_i  (idx_b_i),
  .cond_i   (cond_i),
  .rel_i    (rel_i),
  .pc_i     (pc_i),
  .imm_i    (imm_i),
  .valid_o  (valid_o),
  .taken_o  (taken_o),
  .next_pc_o(next_pc_o)
);

// File: tb/test_branch_eval.sv
module test_branch_eval;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0, rel_i = 1'b0;
  logic [4:0]  idx_a_i = '0, idx_b_i = '0;
  logic [31:0] val_a_i = '0, val_b_i = '0, pc_i = '0, imm_i = '0;
  logic [3:0]  flags_i = '0;
  logic [5:0]  cond_i = '0;
  logic        valid_o, taken_o;
  logic [31:0] next_pc_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  branch_eval i_branch_eval (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_take(input logic [5:0] c, input logic [3:0] f,
                                  input logic [4:0] ia, input logic [4:0] ib,
                                  input logic [31:0] a, input logic [31:0] b);
    bit cm, fl;
    case (c[1:0])
      2'd0: cm = (ia == ib) || (a == b);
      2'd1: cm = (a != b);
      2'd2: cm = (a < b);
      default: cm = (a <= b);
    endcase
    fl = f[c[3:2]];
    case (c[5:4])
      2'd0: return cm;
      2'd1: return cm | fl;
      2'd2: return cm & !fl;
      default: return cm | !fl;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9: reset values
    chk(!valid_o, "R9 valid_o", 32'(valid_o), 0);
    chk(!taken_o, "R9 taken_o", 32'(taken_o), 0);
    chk(next_pc_o == 0, "R9 next_pc_o", next_pc_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!valid_o, "R8 no strobe", 32'(valid_o), 0);

    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 64; c++) begin
        for (int f = 0; f < 16; f++) begin
          for (int r = 0; r < 2; r++) begin
            bit t;
            logic [31:0] epc;
            string tag;
            case (p)
              0: begin idx_a_i = 1; idx_b_i = 2; val_a_i = 5; val_b_i = 5; end
              1: begin idx_a_i = 1; idx_b_i = 2; val_a_i = 3; val_b_i = 9; end
              2: begin idx_a_i = 4; idx_b_i = 6; val_a_i = 32'hFFFF_0000; val_b_i = 3; end
              default: begin idx_a_i = 3; idx_b_i = 3; val_a_i = 7; val_b_i = 4; end
            endcase
            cond_i  = 6'(c);
            flags_i = 4'(f);
            rel_i   = r[0];
            pc_i    = (p == 3) ? 32'hFFFF_FFFF : 32'h1000_0000 + 32'(c * 16 + f);
            imm_i   = 32'h0000_0040 + 32'(p);
            valid_i = 1'b1;
            t = exp_take(cond_i, flags_i, idx_a_i, idx_b_i, val_a_i, val_b_i);
            epc = t ? (rel_i ? imm_i + pc_i : imm_i) : pc_i + 1;
            @(negedge clk_i);
            valid_i = 1'b0;
            chk(valid_o, "R8 valid pulse", 32'(valid_o), 1);
            tag = (p == 3 && c[1:0] == 0) ? "R2 same-index equal" : "R1 R3 R4 taken";
            chk(taken_o == t, tag, 32'(taken_o), 32'(t));
            tag = !t ? "R7 skip" : (rel_i ? "R6 relative" : "R5 absolute");
            chk(next_pc_o == epc, tag, next_pc_o, epc);
            // inputs move without a strobe: outputs must hold
            if (f == 0) begin
              cond_i = ~cond_i; flags_i = ~flags_i; pc_i = pc_i ^ 32'h55;
              imm_i = imm_i ^ 32'hAA; rel_i = ~rel_i;
              @(negedge clk_i);
              chk(!valid_o, "R8 pulse ends", 32'(valid_o), 0);
              chk(taken_o == t, "R8 hold taken", 32'(taken_o), 32'(t));
              chk(next_pc_o == epc, "R8 hold pc", next_pc_o, epc);
            end
          end
        end
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule